// File: doc/BRIEF.md
# Three-Output Reference Clock Divider

This block derives a set of clocks from one reference clock. It produces a processor clock with a one-third high time, an auxiliary clock with half-period high time, a peripheral clock at one sixth of the reference, and a buffered copy of the reference. The processor and auxiliary clocks run at one third of the reference in fast mode and at 1/768 of the reference in slow mode. The peripheral clock and the reference copy do not depend on the mode.

The mode select input is level-sensitive and synchronous to the reference. A slow request must be held for a long, unbroken run of reference cycles before it is taken. A fast request needs only a short unbroken run. A qualified request reaches the processor and auxiliary clocks only when a processor-clock period ends, so a mode change never shortens a pulse. A hold input freezes every derived clock at its current level, and the divider resumes from the same point when hold is released.

There is no data stream here. Every pin is a plain level, so no valid/ready handshake and no back-pressure apply.

Top module: `tri_clock_divider`

## Requirements
- R1: In fast mode, proc_clk repeats every 3 reference cycles and is high for exactly 1 of them. Its rising edge comes on the first reference rising edge after reset is released.
- R2: In slow mode, proc_clk and aux_clk both repeat every 768 reference cycles, and proc_clk is high for the last 256 of them.
- R3: aux_clk rises together with each falling edge of proc_clk and is high for half of its period. In fast mode it is high for 1.5 reference cycles and falls on a reference falling edge. In slow mode it is high for 384 reference cycles.
- R4: per_clk toggles every 3 reference cycles (divide by 6, 50% duty) in both modes. Its first rising edge comes on the third reference rising edge after reset.
- R5: ref_copy follows clk_ref at all times, whatever the mode and whatever the level of hold.
- R6: sel_fast low (0 = slow request) sampled on 195 consecutive reference rising edges qualifies slow mode. A run of 194 low samples leaves the block in fast mode.
- R7: sel_fast high (1 = fast request) sampled on 6 consecutive reference rising edges qualifies fast mode. A run of 5 high samples leaves the block in slow mode.
- R8: A qualified mode change takes effect only at the falling edge of proc_clk that ends a period. Every proc_clk pulse keeps the full length of the mode it started in.
- R9: While hold is high at a reference rising edge, proc_clk, aux_clk and per_clk keep their levels. After release, the sequence continues from where it stopped.
- R10: While rst is high, proc_clk, aux_clk and per_clk are low, and the block starts in fast mode with all counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freezes the derived clocks while high |
| sel_fast | input | 1 | Mode select: 1 requests fast, 0 requests slow (filtered) |
| proc_clk | output | 1 | Processor clock, one-third high time |
| aux_clk | output | 1 | Auxiliary clock, 50% duty, rises at the fall of proc_clk |
| per_clk | output | 1 | Peripheral clock, reference divided by 6 |
| ref_copy | output | 1 | Copy of the reference clock |

## Verification
The bench samples every output twice per reference cycle, once in the high half and once in the low half. This exposes the half-cycle fall of aux_clk and the level of ref_copy.

A steady fast request checks the divide-by-3 waveform shapes. A low pulse one sample short of the slow threshold must leave the waveforms untouched. A long low run must switch to the 768-cycle waveforms at a period boundary. A five-sample high blip in slow mode must change nothing, and a six-sample high run must return to fast mode exactly at the next period end.

A hold window placed mid-sequence separates a true freeze from a reset or skip of the dividers, because the sequence after release must be the one before, shifted by the hold length.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  // one-hot position inside a processor-clock period
  localparam int PHASES = 3;
  typedef logic [PHASES-1:0] phase_t;
  localparam phase_t PH_HEAD = 3'b001; // aux starts here
  localparam phase_t PH_MID  = 3'b010; // reset position
  localparam phase_t PH_TAIL = 3'b100; // proc_clk high
endpackage

// File: rtl/tcd_sel_filter.sv
module tcd_sel_filter #(
  parameter int LOW_HOLD  = 195,
  parameter int HIGH_HOLD = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_fast,
  output logic slow_req
);
  localparam int LW = $clog2(LOW_HOLD + 1);
  localparam int HW = $clog2(HIGH_HOLD + 1);

  logic [LW-1:0] lo_run;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run   <= '0;
      hi_run   <= '0;
      slow_req <= 1'b0;
    end else if (sel_fast) begin
      lo_run <= '0;
      if (hi_run == HW'(HIGH_HOLD - 1)) slow_req <= 1'b0;
      else                              hi_run   <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (lo_run == LW'(LOW_HOLD - 1)) slow_req <= 1'b1;
      else                             lo_run   <= lo_run + 1'b1;
    end
  end
endmodule

// File: rtl/tcd_phase_seq.sv
module tcd_phase_seq
  import tcd_pkg::*;
#(
  parameter int SLOW_PRE = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic slow_req,
  output logic proc_clk,
  output logic aux_clk,
  output logic slow_act
);
  localparam int PW   = (SLOW_PRE > 1) ? $clog2(SLOW_PRE) : 1;
  localparam int HALF = SLOW_PRE / 2;

  phase_t        ph, ph_d;
  logic [PW-1:0] pre, pre_d;
  logic          slow_d;
  logic          tick;
  logic          aux_p, aux_p_d;
  logic          aux_n;

  assign tick = !slow_act || (pre == PW'(SLOW_PRE - 1));

  always_comb begin
    ph_d   = ph;
    pre_d  = pre;
    slow_d = slow_act;
    if (!hold) begin
      if (tick) begin
        ph_d  = {ph[PHASES-2:0], ph[PHASES-1]};
        pre_d = '0;
        if (ph[PHASES-1]) slow_d = slow_req; // period boundary only
      end else begin
        pre_d = pre + 1'b1;
      end
    end
    aux_p_d = ph_d[0] | (slow_d & ph_d[1] & (pre_d < PW'(HALF)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_MID;
      pre      <= '0;
      slow_act <= 1'b0;
      aux_p    <= 1'b0;
    end else begin
      ph       <= ph_d;
      pre      <= pre_d;
      slow_act <= slow_d;
      aux_p    <= aux_p_d;
    end
  end

  // half-cycle extension of the auxiliary clock in fast mode
  always_ff @(negedge clk) begin
    if (rst) aux_n <= 1'b0;
    else     aux_n <= ph[0] & ~slow_act;
  end

  assign proc_clk = ph[PHASES-1];
  assign aux_clk  = aux_p | aux_n;
endmodule

// File: rtl/tcd_per_div.sv
module tcd_per_div #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic per_clk
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per_clk <= 1'b0;
    end else if (!hold) begin
      if (cnt == CW'(HALF_DIV - 1)) begin
        cnt     <= '0;
        per_clk <= ~per_clk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tri_clock_divider.sv
module tri_clock_divider #(
  parameter int SLOW_PRE  = 256,
  parameter int LOW_HOLD  = 195,
  parameter int HIGH_HOLD = 6,
  parameter int PER_HALF  = 3
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic hold,
  input  logic sel_fast,
  output logic proc_clk,
  output logic aux_clk,
  output logic per_clk,
  output logic ref_copy
);
  logic slow_req;
  logic slow_act;

  tcd_sel_filter #(.LOW_HOLD(LOW_HOLD), .HIGH_HOLD(HIGH_HOLD)) u_filter (
    .clk(clk_ref), .rst(rst), .sel_fast(sel_fast), .slow_req(slow_req)
  );

  tcd_phase_seq #(.SLOW_PRE(SLOW_PRE)) u_seq (
    .clk(clk_ref), .rst(rst), .hold(hold), .slow_req(slow_req),
    .proc_clk(proc_clk), .aux_clk(aux_clk), .slow_act(slow_act)
  );

  tcd_per_div #(.HALF_DIV(PER_HALF)) u_per (
    .clk(clk_ref), .rst(rst), .hold(hold), .per_clk(per_clk)
  );

  assign ref_copy = clk_ref;
endmodule

// File: rtl/tcd_checker.sv
module tcd_checker #(
  parameter int LOW_HOLD  = 195,
  parameter int HIGH_HOLD = 6
) (
  input logic clk_ref,
  input logic rst,
  input logic hold,
  input logic sel_fast,
  input logic proc_clk,
  input logic per_clk,
  input logic slow_req,
  input logic slow_act
);
  int lo_seen;
  int hi_seen;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      lo_seen <= 0;
      hi_seen <= 0;
    end else if (sel_fast) begin
      lo_seen <= 0;
      if (hi_seen < HIGH_HOLD) hi_seen <= hi_seen + 1;
    end else begin
      hi_seen <= 0;
      if (lo_seen < LOW_HOLD) lo_seen <= lo_seen + 1;
    end
  end

  // R1: a fast proc_clk pulse lasts one cycle unless held
  a_r1_fast_single_high: assert property (@(posedge clk_ref) disable iff (rst)
    (proc_clk && $past(proc_clk)) |-> (slow_act || $past(hold)));

  // R4: per_clk never toggles on two adjacent edges
  a_r4_per_min_half: assert property (@(posedge clk_ref) disable iff (rst)
    (per_clk != $past(per_clk)) |=> $stable(per_clk));

  // R6: slow qualification needs the full low run
  a_r6_low_run: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(slow_req) |-> (lo_seen >= LOW_HOLD));

  // R7: fast qualification needs the full high run
  a_r7_high_run: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(slow_req) |-> (hi_seen >= HIGH_HOLD));

  // R8: applied mode changes only where a proc_clk period ends
  a_r8_boundary_switch: assert property (@(posedge clk_ref) disable iff (rst)
    (slow_act != $past(slow_act)) |-> ($past(proc_clk) && !proc_clk));

  // R9: hold freezes the derived clocks
  a_r9_hold_freeze: assert property (@(posedge clk_ref) disable iff (rst)
    $past(hold) |-> ($stable(proc_clk) && $stable(per_clk)));
endmodule

bind tri_clock_divider tcd_checker #(.LOW_HOLD(LOW_HOLD), .HIGH_HOLD(HIGH_HOLD)) u_chk (
  .clk_ref(clk_ref), .rst(rst), .hold(hold), .sel_fast(sel_fast),
  .proc_clk(proc_clk), .per_clk(per_clk), .slow_req(slow_req), .slow_act(slow_act)
);

// File: tb/tri_clock_divider_bench.sv
module tri_clock_divider_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold = 1'b0;
  logic sel_fast = 1'b1;
  logic proc_clk, aux_clk, per_clk, ref_copy;

  int k = 0;
  int checks = 0;
  int fails = 0;
  logic sp, sae, sal, spc, srh, srl;

  always #4 clk = ~clk;

  tri_clock_divider u_tri_clock_divider (
    .clk_ref(clk), .rst(rst), .hold(hold), .sel_fast(sel_fast),
    .proc_clk(proc_clk), .aux_clk(aux_clk), .per_clk(per_clk), .ref_copy(ref_copy)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s k=%0d actual=%b expected=%b", req, what, k, act, exp);
    end
  endtask

  // one reference cycle: sample at +2 (clock high) and +6 (clock low)
  task automatic cyc();
    @(posedge clk);
    #2;
    sp = proc_clk; sae = aux_clk; spc = per_clk; srh = ref_copy;
    #4;
    sal = aux_clk; srl = ref_copy;
    k++;
  endtask

  // expected fast waveform at index j (j = 1 is first edge after reset)
  task automatic chk_fast(input string req, input int j);
    chk(req, "proc", sp, (j % 3) == 1);
    chk(req, "aux_hi", sae, (j % 3) != 1);
    chk(req, "aux_lo", sal, (j % 3) == 2);
  endtask

  task automatic chk_per_ref(input int j);
    chk("R4", "per", spc, ((j / 3) % 2) == 1);
    chk("R5", "ref_hi", srh, 1'b1);
    chk("R5", "ref_lo", srl, 1'b0);
  endtask

  task automatic do_reset(input logic sel);
    rst = 1'b1; hold = 1'b0; sel_fast = sel;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R10", "proc", sp, 1'b0);
      chk("R10", "aux", sal, 1'b0);
      chk("R10", "per", spc, 1'b0);
    end
    rst = 1'b0;
    k = 0;
  endtask

  task automatic t_fast_basic();
    do_reset(1'b1);
    for (int i = 0; i < 60; i++) begin
      cyc();
      chk_fast("R1/R3", k);
      chk_per_ref(k);
    end
  endtask

  task automatic t_low_short();
    do_reset(1'b0);
    for (int i = 0; i < 900; i++) begin
      cyc();
      if (k == 194) sel_fast = 1'b1; // 194 low samples only
      chk_fast("R6", k);
    end
  endtask

  task automatic t_slow();
    do_reset(1'b0);
    for (int i = 0; i < 1800; i++) begin
      cyc();
      if (k == 1065) sel_fast = 1'b1; // 5 high samples
      if (k == 1070) sel_fast = 1'b0;
      if (k == 1600) sel_fast = 1'b1; // 6+ high samples
      if (k <= 196) begin
        chk_fast("R6", k);
      end else if (k < 1733) begin
        int m;
        string req;
        m = (k - 197) % 768;
        req = (k > 1070) ? "R7" : "R2";
        chk(req, "proc", sp, m >= 512);
        chk("R3", "aux_hi", sae, m < 384);
        chk("R3", "aux_lo", sal, m < 384);
      end else begin
        chk_fast("R8", k - 1733 + 2);
      end
      chk_per_ref(k);
    end
  endtask

  task automatic t_hold();
    do_reset(1'b1);
    for (int i = 0; i < 60; i++) begin
      cyc();
      if (k <= 10) begin
        chk_fast("R9", k);
      end else if (k <= 30) begin
        chk("R9", "proc", sp, 1'b1);
        chk("R9", "aux_hi", sae, 1'b0);
        chk("R9", "aux_lo", sal, 1'b0);
        chk("R9", "per", spc, 1'b1);
        chk("R5", "ref_hi", srh, 1'b1);
        chk("R5", "ref_lo", srl, 1'b0);
      end else begin
        chk_fast("R9", k - 20);
        chk("R9", "per", spc, (((k - 20) / 3) % 2) == 1);
      end
      if (k == 10) hold = 1'b1;
      if (k == 30) hold = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_fast_basic();
    t_low_short();
    t_slow();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule